// File: doc/BRIEF.md
# Trap Entry and Vector Unit

This block performs the privileged-state update of a 32-bit core at the moment a trap is taken. The core presents a one-cycle trap strobe together with the trap code, an interrupt flag, the faulting value, the PC of the trapped instruction, the current privilege and the current global interrupt-enable bits. On the next clock edge the block picks the handling level from the delegation masks. It then records the cause, the exception PC and the trap value for that level, saves and clears the interrupt enable, and switches the privilege. It also produces the handler address and a one-cycle redirect pulse for the fetch unit.

A synchronous environment call arrives as one generic code. The block renumbers it from the privilege it came from before delegation is decided, so the renumbered code picks the delegation bit. Vectored dispatch is applied only to interrupts. The block also pulses a request that clears any outstanding load reservation held elsewhere in the core.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, priv_o is 3 (machine), redirect_o and resv_clr_o are 0, and every other output is 0.
- R2: The delegation mask consulted is mideleg_i when async_i is 1 and medeleg_i when async_i is 0.
- R3: With privilege encoding U=0, S=1, M=3, a trap is handled at S level (priv_o becomes 1) only when priv_i is 0 or 1 and the selected mask has a 1 at the bit indexed by the effective cause. Otherwise it is handled at M level (priv_o becomes 3). priv_i=2 is never driven.
- R4: An M-level trap sets mpie_o to mie_i, mpp_o to priv_i and mie_o to 0. It sets sie_o to sie_i and leaves spie_o, spp_o, scause_o, sepc_o and stval_o unchanged.
- R5: An S-level trap sets spie_o to sie_i, spp_o to 1 when priv_i is 1 and to 0 when priv_i is 0, and sie_o to 0. It sets mie_o to mie_i and leaves mpie_o, mpp_o, mcause_o, mepc_o and mtval_o unchanged.
- R6: The cause register of the handling level gets bit 31 equal to async_i and bits 4:0 equal to the effective cause, with bits 30:5 zero.
- R7: The exception PC of the handling level gets pc_i.
- R8: The trap value of the handling level gets tval_i only for a synchronous trap with code 0, 1, 4, 5, 6, 7, 12, 13 or 15 (misaligned, access fault, page fault). It gets zero in every other case, including every interrupt.
- R9: handler_pc_o is the handling level's vector base (mtvec_i or stvec_i) with bits 1:0 cleared, plus 4 times the effective cause only when async_i is 1 and the base's bits 1:0 equal 1. Modes 0, 2 and 3 dispatch directly.
- R10: A synchronous trap with code 8 is renumbered to 8, 9 or 11 when priv_i is 0, 1 or 3. The renumbered code is used for delegation, the cause register and dispatch. No other code is renumbered.
- R11: All updates take effect at the clock edge sampling trap_i=1. redirect_o and resv_clr_o are 1 for exactly the following cycle. A cycle with trap_i=0 changes no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap strobe, one cycle per trap |
| async_i | input | 1 | 1 for an interrupt, 0 for an exception |
| cause_i | input | 5 | Raw trap code |
| tval_i | input | 32 | Faulting address or value |
| pc_i | input | 32 | PC of the trapped instruction |
| priv_i | input | 2 | Privilege at the time of the trap |
| mie_i | input | 1 | Current machine interrupt enable |
| sie_i | input | 1 | Current supervisor interrupt enable |
| medeleg_i | input | 32 | Exception delegation mask |
| mideleg_i | input | 32 | Interrupt delegation mask |
| mtvec_i | input | 32 | Machine vector base and mode |
| stvec_i | input | 32 | Supervisor vector base and mode |
| priv_o | output | 2 | New privilege |
| mie_o | output | 1 | Machine interrupt enable after the trap |
| mpie_o | output | 1 | Machine previous interrupt enable |
| mpp_o | output | 2 | Machine previous privilege |
| sie_o | output | 1 | Supervisor interrupt enable after the trap |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mcause_o | output | 32 | Machine cause register |
| mepc_o | output | 32 | Machine exception PC |
| mtval_o | output | 32 | Machine trap value |
| scause_o | output | 32 | Supervisor cause register |
| sepc_o | output | 32 | Supervisor exception PC |
| stval_o | output | 32 | Supervisor trap value |
| handler_pc_o | output | 32 | Address of the trap handler |
| redirect_o | output | 1 | One-cycle pulse: fetch from handler_pc_o |
| resv_clr_o | output | 1 | One-cycle pulse: drop the load reservation |

## Verification
A wrong routing decision shows one cycle after the strobe. The privilege lands at the wrong level, and the cause, PC and value appear in the wrong register set while the other set keeps its old contents. A mis-renumbered environment call or a wrong mask choice shows at the same edge, either as a wrong cause code or as a different target level. A wrong vector offset shows in handler_pc_o, also one cycle after the strobe. Because outputs are held between traps, a stray update on an idle cycle appears as a changed output on the very next sample.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    localparam logic [CAUSE_W-1:0] CODE_ECALL_U = 5'd8;
    localparam logic [CAUSE_W-1:0] CODE_ECALL_S = 5'd9;
    localparam logic [CAUSE_W-1:0] CODE_ECALL_M = 5'd11;

    typedef struct packed {
        logic [1:0]      lvl;
        logic            m_ie;
        logic            m_pie;
        logic [1:0]      m_pp;
        logic            s_ie;
        logic            s_pie;
        logic            s_pp;
        logic [XLEN-1:0] m_cause;
        logic [XLEN-1:0] m_epc;
        logic [XLEN-1:0] m_tval;
        logic [XLEN-1:0] s_cause;
        logic [XLEN-1:0] s_epc;
        logic [XLEN-1:0] s_tval;
        logic [XLEN-1:0] handler;
        logic            jump;
        logic            drop_resv;
    } trap_state_t;
endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
(
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] raw_code,
    input  logic [1:0]         from_lvl,
    output logic [CAUSE_W-1:0] eff_code,
    output logic               addr_kind
);
    always_comb begin
        eff_code = raw_code;
        if (!is_irq && raw_code == CODE_ECALL_U) begin
            unique case (from_lvl)
                LVL_SUPER: eff_code = CODE_ECALL_S;
                LVL_MACH:  eff_code = CODE_ECALL_M;
                default:   eff_code = CODE_ECALL_U;
            endcase
        end
    end

    always_comb begin
        addr_kind = 1'b0;
        if (!is_irq) begin
            unique case (raw_code)
                5'd0, 5'd1, 5'd4, 5'd5, 5'd6,
                5'd7, 5'd12, 5'd13, 5'd15: addr_kind = 1'b1;
                default:                   addr_kind = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
(
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] eff_code,
    input  logic [1:0]         from_lvl,
    input  logic [XLEN-1:0]    exc_mask,
    input  logic [XLEN-1:0]    irq_mask,
    output logic               go_super
);
    logic [XLEN-1:0] sel_mask;
    logic            low_lvl;

    always_comb begin
        sel_mask = is_irq ? irq_mask : exc_mask;
        low_lvl  = (from_lvl == LVL_USER) || (from_lvl == LVL_SUPER);
        go_super = low_lvl && sel_mask[eff_code];
    end
endmodule

// File: rtl/trap_vec.sv
module trap_vec
    import trap_pkg::*;
#(
    parameter bit VEC_EN = 1'b1
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] eff_code,
    input  logic [XLEN-1:0]    base,
    output logic [XLEN-1:0]    target
);
    localparam int OFF_W = CAUSE_W + 2;

    logic [XLEN-1:0] aligned;
    assign aligned = {base[XLEN-1:2], 2'b00};

    generate
        if (VEC_EN) begin : g_vectored
            logic [OFF_W-1:0] offset;
            always_comb begin
                offset = '0;
                if (is_irq && base[1:0] == 2'b01)
                    offset = {eff_code, 2'b00};
                target = aligned + {{(XLEN-OFF_W){1'b0}}, offset};
            end
        end else begin : g_direct
            always_comb target = aligned;
        end
    endgenerate
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter bit VEC_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_i,
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    tval_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [1:0]         priv_i,
    input  logic               mie_i,
    input  logic               sie_i,
    input  logic [XLEN-1:0]    medeleg_i,
    input  logic [XLEN-1:0]    mideleg_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic [XLEN-1:0]    stvec_i,
    output logic [1:0]         priv_o,
    output logic               mie_o,
    output logic               mpie_o,
    output logic [1:0]         mpp_o,
    output logic               sie_o,
    output logic               spie_o,
    output logic               spp_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    handler_pc_o,
    output logic               redirect_o,
    output logic               resv_clr_o
);
    localparam int PAD_W = XLEN - 1 - CAUSE_W;

    trap_state_t st_d, st_q;

    logic [CAUSE_W-1:0] code_eff;
    logic               tval_keep;
    logic               to_super;
    logic [XLEN-1:0]    vec_base;
    logic [XLEN-1:0]    vec_target;
    logic [XLEN-1:0]    cause_word;
    logic [XLEN-1:0]    tval_word;

    trap_cause_fix u_fix (
        .is_irq    (async_i),
        .raw_code  (cause_i),
        .from_lvl  (priv_i),
        .eff_code  (code_eff),
        .addr_kind (tval_keep)
    );

    trap_route u_route (
        .is_irq   (async_i),
        .eff_code (code_eff),
        .from_lvl (priv_i),
        .exc_mask (medeleg_i),
        .irq_mask (mideleg_i),
        .go_super (to_super)
    );

    assign vec_base = to_super ? stvec_i : mtvec_i;

    trap_vec #(.VEC_EN(VEC_EN)) u_vec (
        .is_irq   (async_i),
        .eff_code (code_eff),
        .base     (vec_base),
        .target   (vec_target)
    );

    always_comb begin
        cause_word = {async_i, {PAD_W{1'b0}}, code_eff};
        tval_word  = tval_keep ? tval_i : '0;

        st_d           = st_q;
        st_d.jump      = 1'b0;
        st_d.drop_resv = 1'b0;
        if (trap_i) begin
            st_d.jump      = 1'b1;
            st_d.drop_resv = 1'b1;
            st_d.handler   = vec_target;
            if (to_super) begin
                st_d.lvl     = LVL_SUPER;
                st_d.s_pie   = sie_i;
                st_d.s_pp    = (priv_i == LVL_SUPER);
                st_d.s_ie    = 1'b0;
                st_d.m_ie    = mie_i;
                st_d.s_cause = cause_word;
                st_d.s_epc   = pc_i;
                st_d.s_tval  = tval_word;
            end else begin
                st_d.lvl     = LVL_MACH;
                st_d.m_pie   = mie_i;
                st_d.m_pp    = priv_i;
                st_d.m_ie    = 1'b0;
                st_d.s_ie    = sie_i;
                st_d.m_cause = cause_word;
                st_d.m_epc   = pc_i;
                st_d.m_tval  = tval_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lvl <= LVL_MACH;
        end else begin
            st_q <= st_d;
        end
    end

    assign priv_o       = st_q.lvl;
    assign mie_o        = st_q.m_ie;
    assign mpie_o       = st_q.m_pie;
    assign mpp_o        = st_q.m_pp;
    assign sie_o        = st_q.s_ie;
    assign spie_o       = st_q.s_pie;
    assign spp_o        = st_q.s_pp;
    assign mcause_o     = st_q.m_cause;
    assign mepc_o       = st_q.m_epc;
    assign mtval_o      = st_q.m_tval;
    assign scause_o     = st_q.s_cause;
    assign sepc_o       = st_q.s_epc;
    assign stval_o      = st_q.s_tval;
    assign handler_pc_o = st_q.handler;
    assign redirect_o   = st_q.jump;
    assign resv_clr_o   = st_q.drop_resv;

    // R3: a trap raised from machine level never lands lower
    p_mach_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && priv_i == 2'd3 |=> priv_o == 2'd3);

    // R4: machine entry saves the old enable and level
    p_mach_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && priv_i == 2'd3 |=> !mie_o && mpp_o == 2'd3 && mpie_o == $past(mie_i));

    // R6: interrupt flag lands in the top bit of the cause
    p_cause_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && priv_i == 2'd3 |=> mcause_o[XLEN-1] == $past(async_i));

    // R7: exception PC follows the trapped PC
    p_epc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && priv_i == 2'd3 |=> mepc_o == $past(pc_i));

    // R8: interrupts never leave a trap value behind
    p_irq_tval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && async_i && priv_i == 2'd3 |=> mtval_o == '0);

    // R11: pulses follow a strobe, idle cycles hold state
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i |=> redirect_o && resv_clr_o);
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_i |=> !redirect_o && $stable(mepc_o) && $stable(sepc_o) && $stable(priv_o));
endmodule

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_i, async_i, mie_i, sie_i;
    logic [4:0]  cause_i;
    logic [31:0] tval_i, pc_i, medeleg_i, mideleg_i, mtvec_i, stvec_i;
    logic [1:0]  priv_i;
    logic [1:0]  priv_o, mpp_o;
    logic        mie_o, mpie_o, sie_o, spie_o, spp_o, redirect_o, resv_clr_o;
    logic [31:0] mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o, handler_pc_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // expected model state
    logic [1:0]  e_priv, e_mpp;
    logic        e_mie, e_mpie, e_sie, e_spie, e_spp;
    logic [31:0] e_mcause, e_mepc, e_mtval, e_scause, e_sepc, e_stval, e_pc;

    always #4 clk = ~clk;

    trap_entry_unit dut (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_code(input logic irq, input logic [4:0] c,
                                            input logic [1:0] p);
        if (irq || c != 5'd8) return c;
        if (p == 2'd1) return 5'd9;
        if (p == 2'd3) return 5'd11;
        return 5'd8;
    endfunction

    function automatic logic ref_keeps_tval(input logic irq, input logic [4:0] c);
        logic [31:0] sel;
        sel = 32'h0000_B0F3;
        return !irq && sel[c];
    endfunction

    task automatic compare_all(input string req);
        check(req, "priv",    {30'd0, priv_o}, {30'd0, e_priv});
        check(req, "mie",     {31'd0, mie_o},  {31'd0, e_mie});
        check(req, "mpie",    {31'd0, mpie_o}, {31'd0, e_mpie});
        check(req, "mpp",     {30'd0, mpp_o},  {30'd0, e_mpp});
        check(req, "sie",     {31'd0, sie_o},  {31'd0, e_sie});
        check(req, "spie",    {31'd0, spie_o}, {31'd0, e_spie});
        check(req, "spp",     {31'd0, spp_o},  {31'd0, e_spp});
        check(req, "mcause",  mcause_o, e_mcause);
        check(req, "mepc",    mepc_o,   e_mepc);
        check(req, "mtval",   mtval_o,  e_mtval);
        check(req, "scause",  scause_o, e_scause);
        check(req, "sepc",    sepc_o,   e_sepc);
        check(req, "stval",   stval_o,  e_stval);
        check(req, "handler", handler_pc_o, e_pc);
    endtask

    task automatic take(input logic irq, input logic [4:0] c, input logic [1:0] p,
                        input logic [31:0] tv, input logic [31:0] pc,
                        input logic mi, input logic si, input string req);
        logic [4:0]  ec;
        logic [31:0] mask, base, cw, tw;
        logic        s_lvl;
        @(negedge clk);
        trap_i = 1'b1; async_i = irq; cause_i = c; priv_i = p;
        tval_i = tv; pc_i = pc; mie_i = mi; sie_i = si;
        ec    = ref_code(irq, c, p);
        mask  = irq ? mideleg_i : medeleg_i;                  // R2
        s_lvl = (p == 2'd0 || p == 2'd1) && mask[ec];         // R3
        base  = s_lvl ? stvec_i : mtvec_i;
        cw    = {irq, 26'd0, ec};                             // R6
        tw    = ref_keeps_tval(irq, c) ? tv : 32'd0;          // R8
        e_pc  = (base & 32'hFFFF_FFFC) +
                ((irq && base[1:0] == 2'b01) ? {25'd0, ec, 2'b00} : 32'd0); // R9
        if (s_lvl) begin                                      // R5
            e_priv = 2'd1; e_spie = si; e_spp = (p == 2'd1); e_sie = 1'b0;
            e_mie = mi; e_scause = cw; e_sepc = pc; e_stval = tw;
        end else begin                                        // R4
            e_priv = 2'd3; e_mpie = mi; e_mpp = p; e_mie = 1'b0;
            e_sie = si; e_mcause = cw; e_mepc = pc; e_mtval = tw;
        end
        @(negedge clk);
        trap_i = 1'b0;
        check("R11", "redirect pulse", {31'd0, redirect_o}, 32'd1);
        check("R11", "reservation clear", {31'd0, resv_clr_o}, 32'd1);
        compare_all(req);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R11", "redirect idle", {31'd0, redirect_o}, 32'd0);
        check("R11", "resv idle", {31'd0, resv_clr_o}, 32'd0);
        compare_all("R11");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0; trap_i = 1'b0; async_i = 1'b0; cause_i = '0;
        tval_i = '0; pc_i = '0; priv_i = 2'd3; mie_i = 1'b0; sie_i = 1'b0;
        medeleg_i = '0; mideleg_i = '0; mtvec_i = '0; stvec_i = '0;
        e_priv = 2'd3; e_mpp = 2'd0; e_mie = 0; e_mpie = 0; e_sie = 0; e_spie = 0; e_spp = 0;
        e_mcause = 0; e_mepc = 0; e_mtval = 0; e_scause = 0; e_sepc = 0; e_stval = 0; e_pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "redirect", {31'd0, redirect_o}, 32'd0);
        check("R1", "resv_clr", {31'd0, resv_clr_o}, 32'd0);
        compare_all("R1");

        // R10 environment calls, everything delegated
        medeleg_i = 32'hFFFF_FFFF; mideleg_i = 32'h0;
        mtvec_i = 32'h0000_1001; stvec_i = 32'h0000_2001;
        take(1'b0, 5'd8, 2'd0, 32'hAAAA_0000, 32'h100, 1'b1, 1'b1, "R10");
        take(1'b0, 5'd8, 2'd1, 32'hAAAA_0004, 32'h104, 1'b0, 1'b1, "R10");
        take(1'b0, 5'd8, 2'd3, 32'hAAAA_0008, 32'h108, 1'b1, 1'b0, "R10");
        // R10 renumbered code picks the delegation bit: only bit 9 set
        medeleg_i = 32'h0000_0200;
        take(1'b0, 5'd8, 2'd1, 32'h0, 32'h10C, 1'b1, 1'b1, "R10");
        take(1'b0, 5'd8, 2'd0, 32'h0, 32'h110, 1'b1, 1'b1, "R10");
        idle_check();

        // R2 interrupt uses the interrupt mask only
        medeleg_i = 32'h0; mideleg_i = 32'h0000_0020;
        take(1'b1, 5'd5, 2'd0, 32'h1234_5678, 32'h200, 1'b1, 1'b1, "R2");
        medeleg_i = 32'h0000_0020; mideleg_i = 32'h0;
        take(1'b1, 5'd5, 2'd1, 32'h1234_5678, 32'h204, 1'b1, 1'b1, "R2");
        take(1'b0, 5'd5, 2'd1, 32'hDEAD_BEEF, 32'h208, 1'b0, 1'b0, "R2");

        // R9 vectored interrupt, top code, and direct modes
        mideleg_i = 32'h0; mtvec_i = 32'h8000_0001;
        take(1'b1, 5'd31, 2'd3, 32'h0, 32'h300, 1'b1, 1'b0, "R9");
        mtvec_i = 32'h8000_0002;
        take(1'b1, 5'd7, 2'd3, 32'h0, 32'h304, 1'b1, 1'b0, "R9");
        mtvec_i = 32'h8000_0001;
        take(1'b0, 5'd2, 2'd3, 32'h55, 32'h308, 1'b1, 1'b0, "R9");
        mtvec_i = 32'h8000_0003;
        take(1'b1, 5'd11, 2'd0, 32'h0, 32'h30C, 1'b0, 1'b0, "R9");

        // R8 value-carrying versus plain exceptions
        take(1'b0, 5'd13, 2'd3, 32'hCAFE_0001, 32'h400, 1'b0, 1'b0, "R8");
        take(1'b0, 5'd2,  2'd3, 32'hCAFE_0002, 32'h404, 1'b0, 1'b0, "R8");
        take(1'b0, 5'd14, 2'd3, 32'hCAFE_0003, 32'h408, 1'b0, 1'b0, "R8");
        // R3 machine level ignores delegation
        medeleg_i = 32'hFFFF_FFFF; mideleg_i = 32'hFFFF_FFFF;
        take(1'b0, 5'd15, 2'd3, 32'hCAFE_0004, 32'h40C, 1'b1, 1'b1, "R3");
        take(1'b1, 5'd9,  2'd3, 32'hCAFE_0005, 32'h410, 1'b1, 1'b1, "R3");
        idle_check();

        // random traffic with gaps
        for (int i = 0; i < 400; i++) begin
            logic [1:0] p;
            logic [4:0] c;
            logic       irq;
            medeleg_i = $urandom(); mideleg_i = $urandom();
            mtvec_i = $urandom(); stvec_i = $urandom();
            irq = ($urandom() % 3) == 0;
            c = ($urandom() % 4 == 0) ? 5'd8 : 5'($urandom() % 32);
            case ($urandom() % 3)
                0: p = 2'd0;
                1: p = 2'd1;
                default: p = 2'd3;
            endcase
            take(irq, c, p, $urandom(), $urandom(), 1'($urandom()), 1'($urandom()), "R3");
            if ($urandom() % 4 == 0) idle_check();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule